// File: doc/BRIEF.md
# Readout Statistics Counter Bank

This block keeps eleven saturating counters for a readout board's event and link statistics. Each counter has a one-cycle increment strobe. Nine counters cover these counts:

- missing tokens
- physics triggers
- calibration triggers
- hit-1 words dropped by the threshold
- hit-0 words dropped by the threshold
- words dropped by the per-event word limit
- truncated events
- single hit 1
- single hit 0

Two narrower counters count retransmit requests sent and retransmit requests received. A clear input zeroes the whole bank.

Each counter can be read in two views. The register port gives the absolute value at a fixed address window. The event port gives a formatted status word for the data stream. That word carries the increase since the last statistics-event marker. Each counter keeps a base copy that is loaded when the marker arrives, and the increase is the current count minus that base.

Code 0 in both views is an information word. It is built from the current trigger number and three status flags. Both read ports are registered, so the value appears one cycle after the address or code is presented.

Top module: `stat_bank`

## Requirements
- R1: After reset every counter and every base copy is zero, and both read outputs are zero until the first read.
- R2: A high strobe raises its own counter by exactly one in that cycle. A counter whose strobe is low keeps its value. Strobe bit k-1 belongs to code k for k = 1..9, bit 9 is retransmits sent, and bit 10 is retransmits received.
- R3: A counter at its maximum value (2^CNT_W-1, or 2^RTX_W-1 for the two retransmit counters) stays there on further strobes.
- R4: A clear zeroes all counters and base copies in the next cycle. It wins over a strobe and over a marker in the same cycle.
- R5: Address 0x9100 + code, for codes 0x00..0x1D, returns the absolute value in bits 23..0 of the register data one cycle later. Bits 31..24 are zero.
- R6: Code 0x0A holds retransmits sent in bits RTX_W-1..0 and retransmits received in bits 2*RTX_W-1..RTX_W, with 12 as the default width.
- R7: Code 0x00 holds the trigger number in bits 15..0 and status flags 0, 1 and 2 in bits 16, 17 and 18. Bits 23..19 are zero.
- R8: The event word has bits 31..29 zero, the requested code in bits 28..24, and the data in bits 23..0, one cycle after the code is presented.
- R9: The marker loads every base copy with that counter's value after the same cycle's increment. The event data for codes 1..10 is the count minus the base, per field.
- R10: Codes 0x0B..0x1F give zero data. Addresses outside 0x9100..0x911D read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inc_i | input | 11 | Increment strobes, one per counter |
| clr_i | input | 1 | Clear all counters and base copies |
| snap_i | input | 1 | Statistics-event marker |
| trig_num_i | input | 16 | Current trigger number for code 0 |
| flags_i | input | 3 | Status flags for code 0 |
| reg_addr_i | input | 16 | Register read address |
| reg_data_o | output | 32 | Registered absolute read data |
| evt_code_i | input | 5 | Code of the event word requested |
| evt_word_o | output | 32 | Registered formatted event word |

## Verification
The hardest condition to reach is a counter pinned at saturation while its base copy was loaded below the maximum. The increase must then stop growing, and the two retransmit fields must stay independent inside the shared word. The bench uses narrow counters (8 and 4 bits), so each source can be driven past its maximum within a few hundred cycles. A mixed pattern then strobes each source at its own period across two markers and saturates both retransmit fields. Every code is read in both views against an arithmetic model.

// File: rtl/stat_bank_pkg.sv
package stat_bank_pkg;
    localparam int NSRC      = 11;
    localparam int NPLAIN    = 9;
    localparam int IDX_TX    = 9;
    localparam int IDX_RX    = 10;
    localparam int FLD_W     = 24;
    localparam int CODE_W    = 5;
    localparam logic [15:0] WIN_BASE  = 16'h9100;
    localparam logic [4:0]  LAST_CODE = 5'h1D;
    localparam logic [4:0]  PACK_CODE = 5'h0A;

    typedef logic [FLD_W-1:0] field_t;
    typedef logic [NSRC-1:0][FLD_W-1:0] bank_t;
endpackage

// File: rtl/stat_counter.sv
module stat_counter #(
    parameter int W = 24
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         inc_i,
    input  logic         clr_i,
    input  logic         snap_i,
    output logic [W-1:0] abs_o,
    output logic [W-1:0] rel_o
);
    localparam logic [W-1:0] CNT_MAX = '1;
    localparam logic [W-1:0] ONE     = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] base;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt  = '0;
            st_d.base = '0;
        end else begin
            if (inc_i && (st_q.cnt != CNT_MAX)) begin
                st_d.cnt = st_q.cnt + ONE;
            end
            if (snap_i) begin
                st_d.base = st_d.cnt;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign abs_o = st_q.cnt;
    assign rel_o = st_q.cnt - st_q.base;
endmodule

// File: rtl/stat_fmt.sv
module stat_fmt
    import stat_bank_pkg::*;
#(
    parameter int RTX_W = 12
) (
    input  bank_t       abs_i,
    input  bank_t       rel_i,
    input  logic [15:0] trig_num_i,
    input  logic [2:0]  flags_i,
    input  logic [15:0] reg_addr_i,
    input  logic [4:0]  evt_code_i,
    output logic [31:0] reg_word_o,
    output logic [31:0] evt_word_o
);
    field_t info;
    logic   win_hit;

    function automatic field_t pick(input logic [4:0] code, input bank_t v,
                                    input field_t inf);
        field_t r;
        r = '0;
        if (code == 5'd0) begin
            r = inf;
        end else if (code == PACK_CODE) begin
            r = (v[IDX_RX] << RTX_W) | v[IDX_TX];
        end else begin
            for (int k = 1; k <= NPLAIN; k++) begin
                if (code == 5'(k)) r = v[k-1];
            end
        end
        return r;
    endfunction

    always_comb begin
        info    = {5'b0, flags_i, trig_num_i};
        win_hit = (reg_addr_i[15:5] == WIN_BASE[15:5]) &&
                  (reg_addr_i[4:0] <= LAST_CODE);
        reg_word_o = win_hit ? {8'h00, pick(reg_addr_i[4:0], abs_i, info)} : 32'h0;
        evt_word_o = {3'b000, evt_code_i, pick(evt_code_i, rel_i, info)};
    end
endmodule

// File: rtl/stat_bank.sv
module stat_bank
    import stat_bank_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int RTX_W = 12
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NSRC-1:0]   inc_i,
    input  logic              clr_i,
    input  logic              snap_i,
    input  logic [15:0]       trig_num_i,
    input  logic [2:0]        flags_i,
    input  logic [15:0]       reg_addr_i,
    output logic [31:0]       reg_data_o,
    input  logic [CODE_W-1:0] evt_code_i,
    output logic [31:0]       evt_word_o
);
    typedef struct packed {
        logic [31:0] reg_data;
        logic [31:0] evt_word;
    } out_t;

    bank_t       abs_f, rel_f;
    logic [31:0] reg_word, evt_word;
    out_t        out_d, out_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam int SW = (i < NPLAIN) ? CNT_W : RTX_W;
        logic [SW-1:0] abs_w, rel_w;

        stat_counter #(.W(SW)) cnt_i (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .inc_i  (inc_i[i]),
            .clr_i  (clr_i),
            .snap_i (snap_i),
            .abs_o  (abs_w),
            .rel_o  (rel_w)
        );

        assign abs_f[i] = FLD_W'(abs_w);
        assign rel_f[i] = FLD_W'(rel_w);
    end

    stat_fmt #(.RTX_W(RTX_W)) fmt_i (
        .abs_i      (abs_f),
        .rel_i      (rel_f),
        .trig_num_i (trig_num_i),
        .flags_i    (flags_i),
        .reg_addr_i (reg_addr_i),
        .evt_code_i (evt_code_i),
        .reg_word_o (reg_word),
        .evt_word_o (evt_word)
    );

    always_comb begin
        out_d          = out_q;
        out_d.reg_data = reg_word;
        out_d.evt_word = evt_word;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign reg_data_o = out_q.reg_data;
    assign evt_word_o = out_q.evt_word;
endmodule

// File: rtl/stat_bank_chk.sv
module stat_bank_chk
    import stat_bank_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int RTX_W = 12
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic [NSRC-1:0] inc_i,
    input logic            clr_i,
    input logic            snap_i,
    input logic [15:0]     reg_addr_i,
    input logic [31:0]     reg_data_o,
    input logic [4:0]      evt_code_i,
    input logic [31:0]     evt_word_o,
    input bank_t           abs_f,
    input bank_t           rel_f
);
    localparam field_t ONE_F = FLD_W'(1);

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        localparam int SW = (i < NPLAIN) ? CNT_W : RTX_W;
        localparam field_t MAXV = FLD_W'((64'd1 << SW) - 64'd1);

        AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!clr_i && !inc_i[i]) |=> $stable(abs_f[i])); // R2
        AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!clr_i && inc_i[i] && abs_f[i] != MAXV) |=> (abs_f[i] == $past(abs_f[i]) + ONE_F)); // R2
        AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!clr_i && abs_f[i] == MAXV) |=> (abs_f[i] == MAXV)); // R3
        AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            clr_i |=> (abs_f[i] == '0 && rel_f[i] == '0)); // R4
        AST_SNAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (snap_i && !clr_i) |=> (rel_f[i] == '0)); // R9
    end

    AST_WIN_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_addr_i[15:5] != WIN_BASE[15:5]) |=> (reg_data_o == 32'h0)); // R10
    AST_EVT_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (evt_word_o[28:24] == $past(evt_code_i) && evt_word_o[31:29] == 3'b000)); // R8
endmodule

bind stat_bank stat_bank_chk #(.CNT_W(CNT_W), .RTX_W(RTX_W)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_i      (inc_i),
    .clr_i      (clr_i),
    .snap_i     (snap_i),
    .reg_addr_i (reg_addr_i),
    .reg_data_o (reg_data_o),
    .evt_code_i (evt_code_i),
    .evt_word_o (evt_word_o),
    .abs_f      (abs_f),
    .rel_f      (rel_f)
);

// File: tb/stat_bank_tb_top.sv
module stat_bank_tb_top;
    localparam int CW = 8;
    localparam int RW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] inc = '0;
    logic        clr = 1'b0;
    logic        snap = 1'b0;
    logic [15:0] trig = '0;
    logic [2:0]  flags = '0;
    logic [15:0] addr = '0;
    logic [31:0] reg_data;
    logic [4:0]  ecode = '0;
    logic [31:0] evt_word;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int m_cnt[11];
    int m_base[11];

    always #5 clk = ~clk;

    stat_bank #(.CNT_W(CW), .RTX_W(RW)) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .inc_i      (inc),
        .clr_i      (clr),
        .snap_i     (snap),
        .trig_num_i (trig),
        .flags_i    (flags),
        .reg_addr_i (addr),
        .reg_data_o (reg_data),
        .evt_code_i (ecode),
        .evt_word_o (evt_word)
    );

    function automatic int mx(int i);
        return (i < 9) ? (1 << CW) - 1 : (1 << RW) - 1;
    endfunction

    function automatic int val(int i, bit rel);
        return rel ? ((m_cnt[i] - m_base[i]) & mx(i)) : m_cnt[i];
    endfunction

    // R5/R6/R7/R10: expected 24-bit data for a code
    function automatic int expect_data(int code, bit rel);
        if (code == 0) return (int'(flags) << 16) | int'(trig);
        if (code >= 1 && code <= 9) return val(code - 1, rel);
        if (code == 10) return (val(10, rel) << RW) | val(9, rel);
        return 0;
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp_v);
        total++;
        if (got !== exp_v) begin
            bad++;
            $display("FAIL %s: got=%h expected=%h", req, got, exp_v);
        end
    endtask

    task automatic step(logic [10:0] s, bit c, bit p);
        @(negedge clk);
        inc = s; clr = c; snap = p;
        @(posedge clk);
        for (int i = 0; i < 11; i++) begin
            if (c) begin
                m_cnt[i] = 0; m_base[i] = 0;
            end else begin
                if (s[i] && m_cnt[i] < mx(i)) m_cnt[i]++;
                if (p) m_base[i] = m_cnt[i];
            end
        end
    endtask

    // Reads one code through both ports (R5 register view, R8 event view)
    task automatic read_code(int code, string req);
        logic [31:0] e_reg;
        @(negedge clk);
        inc = '0; clr = 1'b0; snap = 1'b0;
        addr = 16'h9100 + 16'(code);
        ecode = 5'(code);
        @(posedge clk);
        @(negedge clk);
        e_reg = (code <= 29) ? 32'(expect_data(code, 1'b0)) : 32'h0;
        chk({req, " R5 abs"}, reg_data, e_reg);
        chk({req, " R8 evt"}, evt_word, {3'b000, 5'(code), 24'(expect_data(code, 1'b1))});
    endtask

    task automatic read_addr(logic [15:0] a, string req);
        @(negedge clk);
        inc = '0; clr = 1'b0; snap = 1'b0;
        addr = a;
        @(posedge clk);
        @(negedge clk);
        chk(req, reg_data, 32'h0);
    endtask

    task automatic check_all(string req);
        for (int c = 0; c < 32; c++) read_code(c, req);
    endtask

    initial begin
        for (int i = 0; i < 11; i++) begin
            m_cnt[i] = 0; m_base[i] = 0;
        end
        repeat (3) @(posedge clk);
        // R1: outputs zero while in reset and just after
        @(negedge clk);
        chk("R1 reg", reg_data, 32'h0);
        chk("R1 evt", evt_word, 32'h0);
        rst_n = 1'b1;
        check_all("R1");

        // R7: information word
        trig = 16'hBEEF; flags = 3'b101;
        read_code(0, "R7");
        trig = 16'h0412; flags = 3'b010;
        read_code(0, "R7");

        // R2/R3: each source alone, driven past saturation
        for (int i = 0; i < 11; i++) begin
            for (int n = 1; n <= mx(i) + 3; n++) begin
                step(11'(1) << i, 1'b0, 1'b0);
                if (n == 1 || n == mx(i) - 1 || n == mx(i) || n == mx(i) + 3)
                    read_code((i < 9) ? i + 1 : 10, (n > mx(i)) ? "R3" : "R2");
            end
        end
        check_all("R6");
        step('0, 1'b1, 1'b0);
        check_all("R4");

        // R9: mixed periods with two markers
        for (int c = 0; c < 200; c++) begin
            logic [10:0] s;
            s = '0;
            for (int i = 0; i < 11; i++) if (c % (i + 2) == 0) s[i] = 1'b1;
            step(s, 1'b0, (c == 60 || c == 150));
            if (c == 100) check_all("R9");
        end
        check_all("R6");

        // R4: clear beats strobe and marker together
        step('1, 1'b1, 1'b1);
        check_all("R4");

        // R9: marker in the same cycle as an increment
        step(11'h001, 1'b0, 1'b1);
        read_code(1, "R9");
        step(11'h001, 1'b0, 1'b0);
        read_code(1, "R9");

        // R10: addresses outside the window
        read_addr(16'h9000, "R10");
        read_addr(16'h911E, "R10");
        read_addr(16'h9120, "R10");
        read_addr(16'h0105, "R10");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule